// File: doc/BRIEF.md
# Register-Operand ALU Execute Unit

This block carries out the register-to-register and shift instructions of a small processor. It holds the eight 32-bit general-purpose registers. It receives an already decoded instruction: a 4-bit opcode, a 4-bit function code, a source register field, a destination register field and an 8-bit signed shift immediate.

In one cycle the unit reads the operands, computes the result and writes it into the destination register. The destination register is also the first operand, so an instruction has the form `d := d op s` or `d := op(d)`. A separate write port lets a load unit place memory data into a register. The current result is shown on `result_o` at all times. With `exec_en` low and a move selected, this output can be used to read any register without changing state.

Top module: `regop_exec_unit`

## Requirements
- R1: An active-low asynchronous reset clears all eight registers to zero.
- R2: Opcode 0x6 with function 0 copies the source register into the destination register.
- R3: Opcode 0x6 with function 1 adds the source to the destination modulo 2^32. Function 2 ANDs the source into the destination.
- R4: Opcode 0x6 with functions 3 and 4 adds 1 and 4 to the destination. Functions 5 and 6 subtract 1 and 4. All four wrap modulo 2^32.
- R5: Opcode 0x6 with function 7 replaces the destination with its bitwise complement.
- R6: Opcode 0x7 with a shift immediate from 0x00 to 0x7F shifts the destination left by that many bits. Amounts of 32 or more give zero.
- R7: Opcode 0x7 with a shift immediate from 0x80 to 0xFF, read as two's complement, shifts the destination right arithmetically by the magnitude. Magnitudes of 32 or more give all copies of the sign bit. For example, 0xF8 shifts right by 8.
- R8: A register field that is in use and holds a value of 8 to 15 makes the instruction illegal. Functions 0 to 2 use both fields. Functions 3 to 7 and opcode 0x7 use only the destination field, and the unused source field is ignored.
- R9: An opcode other than 0x6 or 0x7, or a function of 8 to 15 with opcode 0x6, is illegal. An illegal instruction never writes a register.
- R10: `err_o` is high exactly when `exec_en` is high and the presented instruction is illegal.
- R11: A register is written only at a rising clock edge, and only by a legal instruction with `exec_en` high or by `load_we`. With both strobes low, no register changes.
- R12: With `load_we` high, `load_data` is written into register `load_sel`. If a legal instruction executes in the same cycle, the execute write is made and the load write is dropped.
- R13: `result_o` shows, without a clock edge, the value that the presented instruction would write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| exec_en | input | 1 | Execute strobe for the presented instruction |
| opcode | input | 4 | Major opcode (0x6 register ALU, 0x7 shift) |
| func | input | 4 | Function code for opcode 0x6 |
| src_sel | input | 4 | Source register field |
| dst_sel | input | 4 | Destination (and first operand) register field |
| shamt | input | 8 | Signed shift immediate |
| load_we | input | 1 | Load-unit write enable |
| load_sel | input | 3 | Load-unit target register |
| load_data | input | 32 | Load-unit write data |
| result_o | output | 32 | Combinational result of the presented instruction |
| err_o | output | 1 | Illegal instruction flag while executing |

## Verification
The in-line properties assume that the inputs are steady and driven at every rising edge after reset, and that `fn` and `shamt` are valid only while a legal instruction is executing. The arithmetic and shift checks are therefore gated on that condition. The stimulus changes the inputs only on falling edges. It sweeps every function over many register pairs, including a source equal to the destination, and all 256 shift immediates. It also applies illegal fields, and it applies load and execute writes in the same cycle. Registers are read back through `result_o` with a move while `exec_en` is held low.

// File: rtl/regop_pkg.sv
package regop_pkg;
   localparam logic [3:0] OPC_REG   = 4'h6;
   localparam logic [3:0] OPC_SHIFT = 4'h7;

   typedef enum logic [2:0] {
      FN_MOV  = 3'd0,
      FN_ADD  = 3'd1,
      FN_AND  = 3'd2,
      FN_INC1 = 3'd3,
      FN_INC4 = 3'd4,
      FN_DEC1 = 3'd5,
      FN_DEC4 = 3'd6,
      FN_NOT  = 3'd7
   } alu_fn_e;
endpackage

// File: rtl/regop_decode.sv
module regop_decode
   import regop_pkg::*;
#(
   parameter int SEL_W   = 4,
   parameter int REG_CNT = 8,
   parameter int IDX_W   = $clog2(REG_CNT)
) (
   input  logic [3:0]       opcode,
   input  logic [3:0]       func,
   input  logic [SEL_W-1:0] src_sel,
   input  logic [SEL_W-1:0] dst_sel,
   output logic             legal,
   output logic             is_shift,
   output alu_fn_e          fn,
   output logic [IDX_W-1:0] src_idx,
   output logic [IDX_W-1:0] dst_idx
);
   logic src_ok, dst_ok, src_used, fn_ok;

   always_comb begin
      src_ok   = src_sel < SEL_W'(REG_CNT);
      dst_ok   = dst_sel < SEL_W'(REG_CNT);
      fn_ok    = func[3] == 1'b0;
      src_used = (opcode == OPC_REG) && (func < 4'd3);
      is_shift = opcode == OPC_SHIFT;
      fn       = alu_fn_e'(func[2:0]);
      src_idx  = src_sel[IDX_W-1:0];
      dst_idx  = dst_sel[IDX_W-1:0];
      legal    = dst_ok && (is_shift || ((opcode == OPC_REG) && fn_ok && (src_ok || !src_used)));
   end
endmodule

// File: rtl/regop_regfile.sv
module regop_regfile #(
   parameter int DATA_W  = 32,
   parameter int REG_CNT = 8,
   parameter int IDX_W   = $clog2(REG_CNT)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [IDX_W-1:0]          widx,
   input  logic [DATA_W-1:0]         wdata,
   input  logic [IDX_W-1:0]          ra_idx,
   output logic [DATA_W-1:0]         ra_data,
   input  logic [IDX_W-1:0]          rb_idx,
   output logic [DATA_W-1:0]         rb_data,
   output logic [REG_CNT*DATA_W-1:0] flat_o
);
   logic [DATA_W-1:0] q [REG_CNT];

   for (genvar i = 0; i < REG_CNT; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        q[i] <= '0;
         else if (we && widx == IDX_W'(i)) q[i] <= wdata;
      end
      assign flat_o[i*DATA_W +: DATA_W] = q[i];

      // R11: a granted write lands in the addressed register at the next edge
      assert_write_lands_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (we && widx == IDX_W'(i)) |=> (q[i] == $past(wdata)));
   end

   assign ra_data = q[ra_idx];
   assign rb_data = q[rb_idx];
endmodule

// File: rtl/regop_alu.sv
module regop_alu
   import regop_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int SHAMT_W     = 8,
   parameter int ADDR_STEP   = 4,
   parameter bit ARITH_RIGHT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               chk_en,
   input  logic               is_shift,
   input  alu_fn_e            fn,
   input  logic [SHAMT_W-1:0] shamt,
   input  logic [DATA_W-1:0]  dval,
   input  logic [DATA_W-1:0]  sval,
   output logic [DATA_W-1:0]  result
);
   localparam int SH_W = $clog2(DATA_W);
   localparam int MAG_W = SHAMT_W + 1;

   logic             go_right, too_far;
   logic [MAG_W-1:0] mag;
   logic [SH_W-1:0]  sh_amt;
   logic [DATA_W-1:0] left_val, right_val, op_val;

   always_comb begin
      go_right = shamt[SHAMT_W-1];
      mag      = go_right ? MAG_W'(-{shamt[SHAMT_W-1], shamt}) : {1'b0, shamt};
      too_far  = mag >= MAG_W'(DATA_W);
      sh_amt   = mag[SH_W-1:0];
      left_val = too_far ? '0 : (dval << sh_amt);
   end

   if (ARITH_RIGHT) begin : g_arith
      assign right_val = too_far ? {DATA_W{dval[DATA_W-1]}}
                                 : DATA_W'($signed(dval) >>> sh_amt);
      // R7: an arithmetic right shift keeps the sign bit
      assert_right_keeps_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (chk_en && is_shift && go_right) |-> (result[DATA_W-1] == dval[DATA_W-1]));
   end else begin : g_logic
      assign right_val = too_far ? '0 : (dval >> sh_amt);
   end

   always_comb begin
      unique case (fn)
         FN_MOV:  op_val = sval;
         FN_ADD:  op_val = dval + sval;
         FN_AND:  op_val = dval & sval;
         FN_INC1: op_val = dval + DATA_W'(1);
         FN_INC4: op_val = dval + DATA_W'(ADDR_STEP);
         FN_DEC1: op_val = dval - DATA_W'(1);
         FN_DEC4: op_val = dval - DATA_W'(ADDR_STEP);
         default: op_val = ~dval;
      endcase
      result = is_shift ? (go_right ? right_val : left_val) : op_val;
   end

   // R3: the sum minus the source gives back the destination operand
   assert_add_inverse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_en && !is_shift && fn == FN_ADD) |-> (result - sval == dval));
   // R4: the address step is exactly the configured step
   assert_step_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_en && !is_shift && fn == FN_INC4) |-> (result - dval == DATA_W'(ADDR_STEP)));
   // R5: complement shares no bit with the operand and covers all bits with it
   assert_complement_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_en && !is_shift && fn == FN_NOT) |-> ((result & dval) == '0 && (&(result | dval))));
   // R6: a nonzero left shift brings in zero at bit 0
   assert_left_fills_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_en && is_shift && !go_right && shamt != '0) |-> (result[0] == 1'b0));
endmodule

// File: rtl/regop_exec_unit.sv
module regop_exec_unit
   import regop_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int REG_CNT     = 8,
   parameter int SEL_W       = 4,
   parameter int SHAMT_W     = 8,
   parameter int ADDR_STEP   = 4,
   parameter bit ARITH_RIGHT = 1'b1,
   localparam int IDX_W      = $clog2(REG_CNT)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               exec_en,
   input  logic [3:0]         opcode,
   input  logic [3:0]         func,
   input  logic [SEL_W-1:0]   src_sel,
   input  logic [SEL_W-1:0]   dst_sel,
   input  logic [SHAMT_W-1:0] shamt,
   input  logic               load_we,
   input  logic [IDX_W-1:0]   load_sel,
   input  logic [DATA_W-1:0]  load_data,
   output logic [DATA_W-1:0]  result_o,
   output logic               err_o
);
   initial begin
      assert (REG_CNT >= 2 && (1 << IDX_W) == REG_CNT) else $error("REG_CNT must be a power of two");
      assert (REG_CNT < (1 << SEL_W)) else $error("SEL_W must leave room for illegal numbers");
      assert ((1 << SHAMT_W) > 2 * DATA_W) else $error("SHAMT_W too small for DATA_W");
   end

   logic              legal, is_shift, exec_we, rf_we;
   alu_fn_e           fn;
   logic [IDX_W-1:0]  src_idx, dst_idx, rf_widx;
   logic [DATA_W-1:0] dval, sval, rf_wdata;
   logic [REG_CNT*DATA_W-1:0] rf_flat;

   regop_decode #(.SEL_W(SEL_W), .REG_CNT(REG_CNT), .IDX_W(IDX_W)) u_dec (
      .opcode(opcode), .func(func), .src_sel(src_sel), .dst_sel(dst_sel),
      .legal(legal), .is_shift(is_shift), .fn(fn), .src_idx(src_idx), .dst_idx(dst_idx));

   regop_alu #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W), .ADDR_STEP(ADDR_STEP),
               .ARITH_RIGHT(ARITH_RIGHT)) u_alu (
      .clk(clk), .rst_n(rst_n), .chk_en(exec_en && legal), .is_shift(is_shift), .fn(fn),
      .shamt(shamt), .dval(dval), .sval(sval), .result(result_o));

   always_comb begin
      exec_we  = exec_en && legal;
      rf_we    = exec_we || load_we;
      rf_widx  = exec_we ? dst_idx : load_sel;
      rf_wdata = exec_we ? result_o : load_data;
      err_o    = exec_en && !legal;
   end

   regop_regfile #(.DATA_W(DATA_W), .REG_CNT(REG_CNT), .IDX_W(IDX_W)) u_rf (
      .clk(clk), .rst_n(rst_n), .we(rf_we), .widx(rf_widx), .wdata(rf_wdata),
      .ra_idx(dst_idx), .ra_data(dval), .rb_idx(src_idx), .rb_data(sval), .flat_o(rf_flat));

   // R9: a rejected instruction leaves every register as it was
   assert_no_write_on_error_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (err_o && !load_we) |=> $stable(rf_flat));
   // R11: with both strobes low the register state holds
   assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!exec_en && !load_we) |=> $stable(rf_flat));
   // R10: the error flag is never raised without the execute strobe
   assert_err_needs_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_en |-> !err_o);
endmodule

// File: tb/sim_regop_exec_unit.sv
module sim_regop_exec_unit;
   logic        clk = 1'b0, rst_n = 1'b0, exec_en = 1'b0, load_we = 1'b0;
   logic [3:0]  opcode = 4'h6, func = 4'h0, src_sel = 4'h0, dst_sel = 4'h0;
   logic [7:0]  shamt = 8'h00;
   logic [2:0]  load_sel = 3'd0;
   logic [31:0] load_data = 32'h0;
   logic [31:0] result_o;
   logic        err_o;
   logic [31:0] m [8];
   int checks = 0, failures = 0;
   string fn_req [8] = '{"R2", "R3", "R3", "R4", "R4", "R4", "R4", "R5"};

   always #5 clk = ~clk;

   regop_exec_unit u0 (.clk(clk), .rst_n(rst_n), .exec_en(exec_en), .opcode(opcode),
      .func(func), .src_sel(src_sel), .dst_sel(dst_sel), .shamt(shamt), .load_we(load_we),
      .load_sel(load_sel), .load_data(load_data), .result_o(result_o), .err_o(err_o));

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] ref_val(logic [3:0] op, logic [3:0] fn, logic [31:0] dv,
                                           logic [31:0] sv, logic [7:0] ss);
      logic [31:0] v = dv;
      if (op == 4'h7) begin
         if (!ss[7]) for (int k = 0; k < int'(ss); k++) v = {v[30:0], 1'b0};
         else for (int k = 0; k < 256 - int'(ss); k++) v = {v[31], v[31:1]};
         return v;
      end
      case (fn[2:0])
         3'd0: return sv;
         3'd1: return dv + sv;
         3'd2: return dv & sv;
         3'd3: return dv + 1;
         3'd4: return dv + 4;
         3'd5: return dv - 1;
         3'd6: return dv - 4;
         default: return ~dv;
      endcase
   endfunction

   function automatic bit ref_legal(logic [3:0] op, logic [3:0] fn, logic [3:0] s, logic [3:0] d);
      if (d >= 8) return 0;
      if (op == 4'h7) return 1;
      if (op != 4'h6 || fn >= 8) return 0;
      if (fn < 3 && s >= 8) return 0;
      return 1;
   endfunction

   task automatic peek(int r, string req);
      @(negedge clk);
      exec_en = 0; load_we = 0; opcode = 4'h6; func = 4'h0; src_sel = 4'(r); dst_sel = 4'h0;
      #1 chk(req, result_o, m[r]);
   endtask

   task automatic load(int r, logic [31:0] v);
      @(negedge clk);
      exec_en = 0; load_we = 1; load_sel = 3'(r); load_data = v;
      @(posedge clk); #1 load_we = 0;
      m[r] = v;
   endtask

   task automatic exec(logic [3:0] op, logic [3:0] fn, logic [3:0] s, logic [3:0] d,
                       logic [7:0] ss, string req);
      bit lg = ref_legal(op, fn, s, d);
      logic [31:0] e = lg ? ref_val(op, fn, m[d[2:0]], m[s[2:0]], ss) : 32'h0;
      @(negedge clk);
      load_we = 0; exec_en = 1; opcode = op; func = fn; src_sel = s; dst_sel = d; shamt = ss;
      #1 chk({req, " err"}, {31'h0, err_o}, {31'h0, !lg});
      if (lg) chk({req, " result"}, result_o, e);
      @(posedge clk); #1 exec_en = 0;
      if (lg) m[d[2:0]] = e;
      peek(int'(d[2:0]), req);
   endtask

   initial begin
      #5_000_000;
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int i = 0; i < 8; i++) m[i] = 32'h0;
      // R1: preload the load port during reset, then expect zeros
      load_we = 1; load_sel = 3'd2; load_data = 32'hDEAD_BEEF;
      repeat (3) @(posedge clk);
      load_we = 0;
      @(negedge clk); rst_n = 1;
      for (int r = 0; r < 8; r++) peek(r, "R1");
      // R12: load port fills every register
      for (int r = 0; r < 8; r++) load(r, 32'h1357_9BDF * (r + 1) ^ 32'hA5A5_0000);
      for (int r = 0; r < 8; r++) peek(r, "R12");
      // R2..R5, R13: every function over many register pairs, s == d included
      for (int f = 0; f < 8; f++)
         for (int d = 0; d < 8; d++) begin
            exec(4'h6, 4'(f), 4'((d + 3) % 8), 4'(d), 8'h00, fn_req[f]);
            exec(4'h6, 4'(f), 4'(d), 4'(d), 8'h00, fn_req[f]);
         end
      // wrap boundaries
      load(1, 32'hFFFF_FFFF); load(2, 32'h1);
      exec(4'h6, 4'h1, 4'h2, 4'h1, 8'h00, "R3");
      exec(4'h6, 4'h5, 4'h0, 4'h1, 8'h00, "R4");
      load(3, 32'hFFFF_FFFE);
      exec(4'h6, 4'h4, 4'h0, 4'h3, 8'h00, "R4");
      load(3, 32'h0000_0002);
      exec(4'h6, 4'h6, 4'h0, 4'h3, 8'h00, "R4");
      // R6/R7: all shift immediates on both sign patterns
      for (int ss = 0; ss < 256; ss++) begin
         load(5, (ss % 2) ? 32'h8123_4567 : 32'h7234_5679);
         exec(4'h7, 4'h0, 4'(ss % 16), 4'h5, 8'(ss), (ss < 128) ? "R6" : "R7");
      end
      load(5, 32'hF000_1200);
      exec(4'h7, 4'h0, 4'h0, 4'h5, 8'hF8, "R7");
      // R8: illegal fields in use, unused source ignored
      for (int d = 8; d < 16; d++) exec(4'h6, 4'h0, 4'h1, 4'(d), 8'h00, "R8");
      for (int d = 8; d < 16; d++) peek(d - 8, "R8");
      for (int s = 8; s < 16; s++) exec(4'h6, 4'(s % 3), 4'(s), 4'(s - 8), 8'h00, "R8");
      exec(4'h6, 4'h3, 4'hC, 4'h4, 8'h00, "R8");
      exec(4'h7, 4'h0, 4'hF, 4'h4, 8'h02, "R8");
      exec(4'h7, 4'h0, 4'h1, 4'h9, 8'h02, "R8");
      peek(1, "R8");
      // R9: unsupported opcodes and functions
      for (int op = 0; op < 16; op++)
         if (op != 6 && op != 7) exec(4'(op), 4'h0, 4'h2, 4'h6, 8'h01, "R9");
      for (int f = 8; f < 16; f++) exec(4'h6, 4'(f), 4'h2, 4'h6, 8'h00, "R9");
      // R10: err_o low without the strobe even on illegal fields
      @(negedge clk);
      exec_en = 0; opcode = 4'h3; func = 4'hF; src_sel = 4'hF; dst_sel = 4'hF;
      #1 chk("R10 idle", {31'h0, err_o}, 32'h0);
      // R11 and R13: result shown, no write without strobe
      @(negedge clk);
      exec_en = 0; opcode = 4'h6; func = 4'h7; src_sel = 4'h0; dst_sel = 4'h4;
      #1 chk("R13 preview", result_o, ~m[4]);
      @(posedge clk);
      peek(4, "R11");
      // R12: execute write wins over a same-cycle load
      @(negedge clk);
      load_we = 1; load_sel = 3'd0; load_data = 32'h0BAD_0BAD;
      exec_en = 1; opcode = 4'h6; func = 4'h3; src_sel = 4'h0; dst_sel = 4'h7;
      @(posedge clk); #1 exec_en = 0; load_we = 0;
      m[7] = m[7] + 1;
      peek(7, "R12"); peek(0, "R12");
      // R12: an illegal execute lets the load through
      @(negedge clk);
      load_we = 1; load_sel = 3'd0; load_data = 32'h0BAD_0BAD;
      exec_en = 1; opcode = 4'h6; func = 4'h0; src_sel = 4'h1; dst_sel = 4'hA;
      @(posedge clk); #1 exec_en = 0; load_we = 0;
      m[0] = 32'h0BAD_0BAD;
      peek(0, "R12");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule